// File: doc/BRIEF.md
# Nonvolatile Memory Write Controller

This block starts and times erase and program operations on a small byte-wide nonvolatile data array. A CPU reaches it through a register bus of three registers: a control register, an address register and a data register. The control register holds a two-bit operation mode, a ready-interrupt enable, an arm bit and a write-strobe bit. The strobe bit doubles as the busy flag. The array is a behavioural register file held inside the block. A second, registered read port lets the surrounding logic observe the array's contents.

A write takes two bus writes in a fixed order. The first sets the arm bit, which hardware drops again after four cycles. The second sets the strobe bit, and it must land while the arm bit is still set. An operation can be an atomic erase-and-program, an erase only, or a program only. Each kind runs for its own number of clock cycles, which a scale parameter derives from millisecond figures. A reset during an operation does not abort it. The ready interrupt is raised when the controller is idle, the interrupt is enabled and the external global enable is set. It is held low while an external self-programming engine is busy.

Top module: `nvm_write_ctrl`

## Requirements
- R1: There are three registers. Register 0 is control, with mode in bits [5:4], interrupt enable in bit 3, arm in bit 2 and strobe/busy in bit 1. Register 1 is the address and register 2 is the data. Control bits 7, 6 and 0 and the whole of register 3 read as zero. `bus_rdata` shows the register selected by `bus_addr` one cycle later.
- R2: Writing a 1 to the arm bit sets it. It then reads as 1 for exactly four cycles and clears by itself.
- R3: A strobe write starts an operation only if the arm bit was set by an earlier write whose four-cycle window is still open. A strobe with no arm bit set, or a strobe written in the same write as the arm bit, has no effect.
- R4: An atomic operation (mode 00) keeps the busy flag set for 34·S cycles. An erase-only (01) or program-only (10) operation keeps it set for 18·S cycles. S is the cycles-per-100-µs parameter.
- R5: At completion the addressed byte is updated. Mode 00 stores the data byte, mode 01 stores 0xFF, and mode 10 stores the old byte ANDed with the data byte.
- R6: A strobe with mode 11 completes at once. The busy flag is never set and the array is unchanged.
- R7: While busy, writes to the mode field are ignored. Other control bits still take writes.
- R8: Reset clears the mode to 00 only when no operation is in progress. An operation in progress survives reset and completes normally.
- R9: `irq_o` is high exactly when the interrupt enable, `gie_i` and not-busy all hold and `spm_busy_i` is low.
- R10: A strobe is ignored while `spm_busy_i` is high or while an operation is already running.
- R11: Address and data are captured when an operation starts. Register writes during the operation do not change its target or value.
- R12: `peek_data` returns the array byte at `peek_addr` one cycle later. The array powers up with all bytes 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | DW | Register write data |
| bus_rdata | output | DW | Registered read data of selected register |
| gie_i | input | 1 | Global interrupt enable |
| spm_busy_i | input | 1 | Self-programming engine busy |
| irq_o | output | 1 | Ready interrupt |
| peek_addr | input | AW | Array observation address |
| peek_data | output | DW | Array observation data (one-cycle latency) |

## Verification
The main function is driven with random sequences of the three real modes over random addresses and data bytes, with random arm-to-strobe gaps inside the window. A per-byte model tells apart store, erase and AND-merge results, and the cycle of the interrupt edge tells the two operation lengths apart. Directed patterns cover the rest. A gap of three idle cycles must start an operation, and a gap of four must not. An arm and a strobe in one write, mode 11, a strobe while the external engine is busy, a second strobe during an operation, and register rewrites during an operation each separate an accepted start from one that is ignored. A reset in the middle of an operation separates resetting the mode from preserving it.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    MODE_ATOMIC = 2'b00,
    MODE_ERASE  = 2'b01,
    MODE_PROG   = 2'b10,
    MODE_RSVD   = 2'b11
  } nvm_mode_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_ADDR = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;

  localparam int CTL_MODE_LO = 4;
  localparam int CTL_IE      = 3;
  localparam int CTL_ARM     = 2;
  localparam int CTL_STROBE  = 1;

  localparam int ATOM_TENTHS   = 34;
  localparam int SINGLE_TENTHS = 18;
endpackage

// File: rtl/nvm_arm_timer.sv
module nvm_arm_timer #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic armed_o
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      armed_o <= 1'b0;
      cnt_q   <= '0;
    end else if (set_i) begin
      armed_o <= 1'b1;
      cnt_q   <= CW'(WIN - 1);
    end else if (armed_o) begin
      if (cnt_q == '0) armed_o <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer import nvm_pkg::*; #(
  parameter int ATOM_CYC   = 68,
  parameter int SINGLE_CYC = 36
) (
  input  logic      clk,
  input  logic      start_i,
  input  nvm_mode_e mode_i,
  output logic      busy_o,
  output logic      done_o
);
  localparam int MAXC = (ATOM_CYC > SINGLE_CYC) ? ATOM_CYC : SINGLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  // Deliberately not reset: an operation in progress outlives a reset.
  logic          busy_q = 1'b0;
  logic [CW-1:0] cnt_q  = '0;

  always_ff @(posedge clk) begin
    if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= (mode_i == MODE_ATOMIC) ? CW'(ATOM_CYC - 1) : CW'(SINGLE_CYC - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] ra_addr_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [AW-1:0] rb_addr_i,
  output logic [DW-1:0] rb_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    ra_data_o <= mem[ra_addr_i];
    rb_data_o <= mem[rb_addr_i];
  end
endmodule

// File: rtl/nvm_write_ctrl.sv
module nvm_write_ctrl import nvm_pkg::*; #(
  parameter int AW              = 6,
  parameter int DW              = 8,
  parameter int TICKS_PER_100US = 2,
  parameter int ARM_WIN         = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          gie_i,
  input  logic          spm_busy_i,
  output logic          irq_o,
  input  logic [AW-1:0] peek_addr,
  output logic [DW-1:0] peek_data
);
  localparam int ATOM_CYC   = ATOM_TENTHS * TICKS_PER_100US;
  localparam int SINGLE_CYC = SINGLE_TENTHS * TICKS_PER_100US;

  nvm_mode_e     mode_q;
  logic          ie_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          armed, busy, done;

  nvm_mode_e     lat_mode;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_data;
  logic [DW-1:0] old_byte, new_byte;

  logic      ctrl_wr, strobe_ok, op_go;
  nvm_mode_e wr_mode;

  assign ctrl_wr   = bus_wr && (bus_addr == REG_CTRL) && !rst;
  assign wr_mode   = nvm_mode_e'(bus_wdata[CTL_MODE_LO+1:CTL_MODE_LO]);
  assign strobe_ok = ctrl_wr && bus_wdata[CTL_STROBE] && armed && !busy && !spm_busy_i;
  assign op_go     = strobe_ok && (wr_mode != MODE_RSVD);

  nvm_arm_timer #(.WIN(ARM_WIN)) u_arm (
    .clk     (clk),
    .rst     (rst),
    .set_i   (ctrl_wr && bus_wdata[CTL_ARM]),
    .clr_i   (strobe_ok),
    .armed_o (armed)
  );

  nvm_op_timer #(.ATOM_CYC(ATOM_CYC), .SINGLE_CYC(SINGLE_CYC)) u_timer (
    .clk     (clk),
    .start_i (op_go),
    .mode_i  (wr_mode),
    .busy_o  (busy),
    .done_o  (done)
  );

  nvm_array #(.AW(AW), .DW(DW)) u_array (
    .clk       (clk),
    .we_i      (done),
    .waddr_i   (lat_addr),
    .wdata_i   (new_byte),
    .ra_addr_i (lat_addr),
    .ra_data_o (old_byte),
    .rb_addr_i (peek_addr),
    .rb_data_o (peek_data)
  );

  // Register bank; the mode survives a reset taken during an operation.
  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      if (!busy) mode_q <= MODE_ATOMIC;
    end else if (bus_wr) begin
      case (bus_addr)
        REG_CTRL: begin
          ie_q <= bus_wdata[CTL_IE];
          if (!busy) mode_q <= wr_mode;
        end
        REG_ADDR: addr_q <= bus_wdata[AW-1:0];
        REG_DATA: data_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  // Operation operands captured at start.
  always_ff @(posedge clk) begin
    if (op_go) begin
      lat_mode <= wr_mode;
      lat_addr <= addr_q;
      lat_data <= data_q;
    end
  end

  always_comb begin
    case (lat_mode)
      MODE_ATOMIC: new_byte = lat_data;
      MODE_ERASE:  new_byte = '1;
      MODE_PROG:   new_byte = old_byte & lat_data;
      default:     new_byte = old_byte;
    endcase
  end

  // Registered read mux.
  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        REG_CTRL: bus_rdata <= DW'({2'b00, mode_q, ie_q, armed, busy, 1'b0});
        REG_ADDR: bus_rdata <= DW'(addr_q);
        REG_DATA: bus_rdata <= data_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign irq_o = ie_q && gie_i && !busy && !spm_busy_i;

  // R3
  start_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(armed));

  // R10
  start_not_spm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(spm_busy_i));

  // R6
  start_not_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (lat_mode != MODE_RSVD));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mode_q));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (busy || spm_busy_i) |-> !irq_o);
endmodule

// File: tb/test_nvm_write_ctrl.sv
module test_nvm_write_ctrl;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int D_ATOM = 68;
  localparam int D_ONE  = 36;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          gie_i = 1'b1;
  logic          spm_busy_i = 1'b0;
  logic          irq_o;
  logic [AW-1:0] peek_addr = '0;
  logic [DW-1:0] peek_data;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;
  logic [7:0] model [64];

  always #10 clk = ~clk;

  nvm_write_ctrl i_nvm_write_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie_i(gie_i),
    .spm_busy_i(spm_busy_i), .irq_o(irq_o), .peek_addr(peek_addr),
    .peek_data(peek_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dur_of(int m);
    return (m == 0) ? D_ATOM : D_ONE;
  endfunction

  function automatic logic [7:0] merge(int m, logic [7:0] old, logic [7:0] d);
    case (m)
      0: return d;
      1: return 8'hFF;
      2: return old & d;
      default: return old;
    endcase
  endfunction

  function automatic logic [7:0] ctl(int m, bit ie, bit arm, bit stb);
    return {2'b00, 2'(m), ie, arm, stb, 1'b0};
  endfunction

  // Called at a negedge; the write lands on the next posedge.
  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic peek(int a, output logic [7:0] v);
    peek_addr = AW'(a);
    @(negedge clk);
    v = peek_data;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready();
    logic [7:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(2'd0, v);
      if (v[1] == 1'b0) break;
    end
  endtask

  // Full operation with timing check through the interrupt edge.
  task automatic do_op(int m, int a, logic [7:0] d, int gap);
    logic [7:0] v;
    wr(2'd1, 8'(a));
    wr(2'd2, d);
    wr(2'd0, ctl(m, 1, 1, 0));
    idle(gap);
    wr(2'd0, ctl(m, 1, 0, 1));
    chk("R9 irq low at start", irq_o, 0);
    idle(dur_of(m) - 1);
    chk("R4 still busy at last cycle", irq_o, 0);
    idle(1);
    chk("R4 ready after duration", irq_o, 1);
    model[a] = merge(m, model[a], d);
    peek(a, v);
    chk("R5 array byte", v, model[a]);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) model[i] = 8'hFF;
    idle(3);
    rst = 1'b0;
    idle(1);

    // Reset state
    rd(2'd0, v); chk("R8 ctrl after reset", v, 8'h00);
    chk("R9 irq off with ie clear", irq_o, 0);
    peek(7, v);  chk("R12 array powers up erased", v, 8'hFF);

    // R1: reserved bits and register 3
    wr(2'd0, 8'hFF);
    rd(2'd0, v); chk("R1 ctrl readback reserved zero", v, 8'h3C);
    chk("R3 same-write strobe ignored", v[1], 0);
    rd(2'd3, v); chk("R1 unused register reads zero", v, 8'h00);
    idle(6);
    wr(2'd1, 8'h2A); rd(2'd1, v); chk("R1 address register", v, 8'h2A);
    wr(2'd2, 8'hC3); rd(2'd2, v); chk("R1 data register", v, 8'hC3);

    // R2: arm window of four cycles
    wr(2'd0, ctl(0, 1, 1, 0));
    for (int k = 0; k < 4; k++) begin
      rd(2'd0, v); chk("R2 arm held", v[2], 1);
    end
    rd(2'd0, v); chk("R2 arm cleared after four", v[2], 0);

    // R3: strobe without arm
    wr(2'd0, ctl(0, 1, 0, 1));
    rd(2'd0, v); chk("R3 strobe without arm ignored", v[1], 0);
    chk("R3 irq still high", irq_o, 1);

    // R3 boundary: gap 4 too late, gap 3 accepted
    wr(2'd1, 8'd9); wr(2'd2, 8'h55);
    wr(2'd0, ctl(0, 1, 1, 0)); idle(4); wr(2'd0, ctl(0, 1, 0, 1));
    rd(2'd0, v); chk("R3 strobe after window ignored", v[1], 0);
    do_op(0, 9, 8'h55, 3);

    // R5: each mode directed
    do_op(2, 9, 8'h0F, 0);
    do_op(1, 9, 8'h00, 1);
    do_op(2, 10, 8'hA5, 2);

    // R6: reserved mode
    wr(2'd1, 8'd10); wr(2'd2, 8'h00);
    wr(2'd0, ctl(3, 1, 1, 0)); wr(2'd0, ctl(3, 1, 0, 1));
    chk("R6 rsvd never busy irq", irq_o, 1);
    rd(2'd0, v); chk("R6 rsvd busy clear", v[1], 0);
    peek(10, v); chk("R6 rsvd array unchanged", v, model[10]);

    // R10: external engine busy blocks start; R9 irq low
    spm_busy_i = 1'b1;
    wr(2'd0, ctl(0, 1, 1, 0)); wr(2'd0, ctl(0, 1, 0, 1));
    chk("R9 irq low while spm busy", irq_o, 0);
    rd(2'd0, v); chk("R10 strobe ignored while spm busy", v[1], 0);
    spm_busy_i = 1'b0;
    idle(5);
    peek(10, v); chk("R10 array unchanged", v, model[10]);

    // R11 + R10 + R7: rewrite regs and strobe during an operation
    wr(2'd1, 8'd20); wr(2'd2, 8'h12);
    wr(2'd0, ctl(1, 1, 1, 0)); wr(2'd0, ctl(1, 1, 0, 1));
    wr(2'd1, 8'd21); wr(2'd2, 8'h34);
    wr(2'd0, ctl(0, 1, 1, 0)); wr(2'd0, ctl(0, 1, 0, 1));
    rd(2'd0, v); chk("R7 mode write ignored while busy", v[5:4], 1);
    idle(D_ONE - 6);
    chk("R10 second strobe kept duration", irq_o, 0);
    idle(1);
    chk("R10 finished at first duration", irq_o, 1);
    model[20] = 8'hFF;
    peek(20, v); chk("R11 latched address erased", v, 8'hFF);
    peek(21, v); chk("R11 later address untouched", v, model[21]);

    // R8: reset during an operation
    wr(2'd1, 8'd30); wr(2'd2, 8'h81);
    wr(2'd0, ctl(2, 1, 1, 0)); wr(2'd0, ctl(2, 1, 0, 1));
    idle(3);
    rst = 1'b1; idle(1); rst = 1'b0;
    rd(2'd0, v); chk("R8 mode kept during op", v[5:4], 2);
    chk("R8 op still busy after reset", v[1], 1);
    wait_ready();
    model[30] = merge(2, model[30], 8'h81);
    peek(30, v); chk("R8 op completed across reset", v, model[30]);
    rst = 1'b1; idle(1); rst = 1'b0;
    rd(2'd0, v); chk("R8 mode cleared when idle", v, 8'h00);

    // Random operations
    for (int n = 0; n < 16; n++) begin
      int m, a, g;
      logic [7:0] d;
      m = int'($urandom_range(0, 2));
      a = int'($urandom_range(0, 63));
      g = int'($urandom_range(0, 3));
      d = 8'($urandom);
      do_op(m, a, d, g);
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule